// File: doc/BRIEF.md
# Scatter-Gather Storage DMA Engine

This block is the bus-master half of a storage host controller. Software places a table of descriptors in memory, loads the table's base address, then writes a control byte that starts the engine. The engine fetches one descriptor at a time over a simple memory request channel. Each descriptor is two 32-bit little-endian words: a byte address first, then a byte length. The engine then moves the region 16 bits at a time, either from memory to the device data port or from the device data port into memory. Bit 0 of the address word marks the last entry in the table. Only the low 29 bits of the length word count.

Data streams use valid/ready handshakes. A producer holds valid and its payload steady until the consumer shows ready, and a beat moves on the clock edge where both are high. The memory request channel follows the same rule. The engine keeps at most one read outstanding and always accepts a read response, so the response channel carries valid only. A device-side interrupt input is recorded in the status byte. Control and status pins are plain levels and strobes.

Top module: `sgdma_top`

## Requirements
- R1: After reset the status byte is zero, and `mem_req_valid`, `dev_tx_valid` and `dev_rx_ready` are low.
- R2: Bit 0 of a descriptor's address word is the end-of-table flag. The data address is that word with bit 0 forced to zero. A read response returns the addressed halfword in bits 15:0, which for address bit 1 set is the upper half of the 32-bit word.
- R3: Without the end flag, the next descriptor is fetched 8 bytes past the previous one. Data moves in table order and in ascending address order within each entry.
- R4: With control bit 2 clear, each halfword is read from memory and offered on the device transmit stream.
- R5: With control bit 2 set, each halfword taken from the device receive stream is written to memory, at ascending halfword addresses.
- R6: Only bits 28:0 of the length word are used. Bits 31:29 are ignored. A zero length moves no data.
- R7: A length that is not a multiple of 2 sets status bit 2 (error), clears the active bit and moves no data.
- R8: Status bit 0 is one while the engine runs. When the last entry's length is used up, status bit 1 (normal end) is set on the same clock edge that status bit 0 drops.
- R9: Writing control bit 1 (stop) while active aborts the transfer. Status bit 0 clears on the next edge, and no further memory requests or device beats follow.
- R10: Control bit 7 holds the engine in reset and clears the status flags. A start (bit 0) is accepted only when bit 7 was clear before the write and is clear in the write itself.
- R11: Writes to the table base register are ignored while status bit 0 is one.
- R12: A pulse on `dev_irq` sets status bit 4, which stays set until the next accepted start.
- R13: A memory read request, and a transmit beat, each hold valid and payload stable until accepted, except when an abort or reset hold cancels them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr | input | 1 | Strobe: load table base address |
| base_wdata | input | 32 | Table base byte address |
| ctrl_wr | input | 1 | Strobe: write control byte |
| ctrl_wdata | input | 8 | Control: bit0 start, bit1 stop, bit2 direction, bit7 reset hold |
| status | output | 8 | bit0 active, bit1 normal end, bit2 error, bit4 device interrupt |
| dev_irq | input | 1 | Device interrupt pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = halfword write, 0 = read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 16 | Write halfword |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| dev_tx_valid | output | 1 | Transmit beat valid (memory to device) |
| dev_tx_ready | input | 1 | Device takes transmit beat |
| dev_tx_data | output | 16 | Transmit halfword |
| dev_rx_valid | input | 1 | Receive beat valid (device to memory) |
| dev_rx_ready | output | 1 | Engine takes receive beat |
| dev_rx_data | input | 16 | Receive halfword |

## Verification
Some behaviours are checked on every clock by properties. Requests and transmit beats hold steady under back-pressure. An odd length leads straight to idle. An accepted stop clears the active state on the next edge. The table base does not change during a run. Normal end never rises while active. Only the bench's scenarios can show the rest. Those are the transferred values and their order across several entries, and the direction selection. They also cover the masking of the length word's top bits, the reset-hold rule on start, and a base write made mid-run landing nowhere.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FA_REQ,
    S_FA_WAIT,
    S_FL_REQ,
    S_FL_WAIT,
    S_CHECK,
    S_RD_REQ,
    S_RD_WAIT,
    S_TX,
    S_WR
  } eng_state_t;

  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_DIR   = 2;
  localparam int CTL_HOLD  = 7;

  localparam int ST_ACTIVE = 0;
  localparam int ST_NEND   = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_DEVINT = 4;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] ctrl_wdata,
  input  logic          dev_irq,
  input  logic          eng_active,
  input  logic          eng_done,
  input  logic          eng_err,
  output logic [AW-1:0] base_q,
  output logic          start_o,
  output logic          start_dir_o,
  output logic          kill_o,
  output logic [CW-1:0] status_o
);
  logic hold_q, nend_q, err_q, devint_q, abort_w;

  // a start needs the hold bit clear both before and in the write
  assign start_o = ctrl_wr && ctrl_wdata[CTL_START] && !ctrl_wdata[CTL_STOP]
                   && !ctrl_wdata[CTL_HOLD] && !hold_q && !eng_active;
  assign start_dir_o = ctrl_wdata[CTL_DIR];
  assign abort_w = ctrl_wr && eng_active
                   && (ctrl_wdata[CTL_STOP] || ctrl_wdata[CTL_HOLD]);
  assign kill_o  = abort_w || hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      hold_q   <= 1'b0;
      nend_q   <= 1'b0;
      err_q    <= 1'b0;
      devint_q <= 1'b0;
    end else begin
      if (base_wr && !eng_active) base_q <= base_wdata;
      if (ctrl_wr) hold_q <= ctrl_wdata[CTL_HOLD];
      if (start_o || (ctrl_wr && ctrl_wdata[CTL_HOLD])) begin
        nend_q   <= 1'b0;
        err_q    <= 1'b0;
        devint_q <= 1'b0;
      end
      if (eng_done) nend_q <= 1'b1;
      if (eng_err)  err_q  <= 1'b1;
      if (dev_irq)  devint_q <= 1'b1;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[ST_ACTIVE] = eng_active;
    status_o[ST_NEND]   = nend_q;
    status_o[ST_ERR]    = err_q;
    status_o[ST_DEVINT] = devint_q;
  end

  // R11
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |=> $stable(base_q));
  // R8
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nend_q) |-> !eng_active);
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !eng_active);
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int WW = 32,
  parameter int DW = 16,
  parameter int LW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          start_dir_i,
  input  logic          kill_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [WW-1:0] mem_rsp_data,
  output logic          dev_tx_valid,
  input  logic          dev_tx_ready,
  output logic [DW-1:0] dev_tx_data,
  input  logic          dev_rx_valid,
  output logic          dev_rx_ready,
  input  logic [DW-1:0] dev_rx_data,
  output logic          active_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int STEP = DW / 8;
  localparam int WORD_BYTES = WW / 8;
  localparam logic [LW-1:0] STEP_L  = LW'(STEP);
  localparam logic [LW-1:0] ALIGN_M = LW'(STEP - 1);
  localparam logic [AW-1:0] STEP_A  = AW'(STEP);
  localparam logic [AW-1:0] LEN_OFS = AW'(WORD_BYTES);
  localparam logic [AW-1:0] DESC_SZ = AW'(2 * WORD_BYTES);

  eng_state_t    state;
  logic [AW-1:0] table_ptr, cur_addr;
  logic [LW-1:0] rem;
  logic          last_q, dir_q;
  logic [DW-1:0] hold_data;
  logic          beat_fire, last_beat, odd_len, entry_empty;

  assign beat_fire   = (state == S_TX && dev_tx_ready) ||
                       (state == S_WR && dev_rx_valid && mem_req_ready);
  assign last_beat   = (rem == STEP_L);
  assign odd_len     = (rem & ALIGN_M) != '0;
  assign entry_empty = (rem == '0);
  assign active_o    = (state != S_IDLE);
  assign done_o = !kill_i && last_q &&
                  ((beat_fire && last_beat) ||
                   (state == S_CHECK && !odd_len && entry_empty));
  assign err_o  = !kill_i && state == S_CHECK && odd_len;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = cur_addr;
    unique case (state)
      S_FA_REQ: begin mem_req_valid = 1'b1; mem_req_addr = table_ptr; end
      S_FL_REQ: begin mem_req_valid = 1'b1; mem_req_addr = table_ptr + LEN_OFS; end
      S_RD_REQ: mem_req_valid = 1'b1;
      S_WR: begin mem_req_valid = dev_rx_valid; mem_req_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_req_wdata = dev_rx_data;
  assign dev_rx_ready  = (state == S_WR) && mem_req_ready;
  assign dev_tx_valid  = (state == S_TX);
  assign dev_tx_data   = hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      table_ptr <= '0;
      cur_addr  <= '0;
      rem       <= '0;
      last_q    <= 1'b0;
      dir_q     <= 1'b0;
      hold_data <= '0;
    end else if (kill_i) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          table_ptr <= base_i;
          dir_q     <= start_dir_i;
          state     <= S_FA_REQ;
        end
        S_FA_REQ: if (mem_req_ready) state <= S_FA_WAIT;
        S_FA_WAIT: if (mem_rsp_valid) begin
          cur_addr <= {mem_rsp_data[AW-1:1], 1'b0};
          last_q   <= mem_rsp_data[0];
          state    <= S_FL_REQ;
        end
        S_FL_REQ: if (mem_req_ready) state <= S_FL_WAIT;
        S_FL_WAIT: if (mem_rsp_valid) begin
          rem       <= mem_rsp_data[LW-1:0];
          table_ptr <= table_ptr + DESC_SZ;
          state     <= S_CHECK;
        end
        S_CHECK: begin
          if (odd_len)          state <= S_IDLE;
          else if (entry_empty) state <= last_q ? S_IDLE : S_FA_REQ;
          else                  state <= dir_q ? S_WR : S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          hold_data <= mem_rsp_data[DW-1:0];
          state     <= S_TX;
        end
        S_TX, S_WR: if (beat_fire) begin
          cur_addr <= cur_addr + STEP_A;
          rem      <= rem - STEP_L;
          if (last_beat) state <= last_q ? S_IDLE : S_FA_REQ;
          else           state <= dir_q ? S_WR : S_RD_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  odd_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && odd_len && !kill_i) |=> (state == S_IDLE));
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !mem_req_we && !kill_i)
      |=> (mem_req_valid && $stable(mem_req_addr)));
  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid && !dev_tx_ready && !kill_i)
      |=> (dev_tx_valid && $stable(dev_tx_data)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !active_o);
endmodule

// File: rtl/sgdma_top.sv
module sgdma_top #(
  parameter int AW = 32,
  parameter int WW = 32,
  parameter int DW = 16,
  parameter int LW = 29,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] ctrl_wdata,
  output logic [CW-1:0] status,
  input  logic          dev_irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [WW-1:0] mem_rsp_data,
  output logic          dev_tx_valid,
  input  logic          dev_tx_ready,
  output logic [DW-1:0] dev_tx_data,
  input  logic          dev_rx_valid,
  output logic          dev_rx_ready,
  input  logic [DW-1:0] dev_rx_data
);
  logic [AW-1:0] base_q;
  logic start_w, start_dir_w, kill_w, active_w, done_w, err_w;

  sgdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .base_wr(base_wr), .base_wdata(base_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .dev_irq(dev_irq),
    .eng_active(active_w), .eng_done(done_w), .eng_err(err_w),
    .base_q(base_q), .start_o(start_w), .start_dir_o(start_dir_w),
    .kill_o(kill_w), .status_o(status)
  );

  sgdma_engine #(.AW(AW), .WW(WW), .DW(DW), .LW(LW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_w), .start_dir_i(start_dir_w), .kill_i(kill_w),
    .base_i(base_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
    .dev_rx_data(dev_rx_data),
    .active_o(active_w), .done_o(done_w), .err_o(err_w)
  );
endmodule

// File: tb/test_sgdma_top.sv
`timescale 1ns/1ps
module test_sgdma_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_wr = 1'b0, ctrl_wr = 1'b0, dev_irq = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [7:0]  ctrl_wdata = '0, status;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic [15:0] mem_req_wdata, dev_tx_data, dev_rx_data;
  logic dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready;

  always #4 clk = ~clk;

  sgdma_top i_sgdma_top (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .status(status), .dev_irq(dev_irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data)
  );

  // memory model, ready patterns, device stubs
  logic [31:0] mem [0:127];
  logic        fill_req = 1'b0, poke_en = 1'b0;
  logic [6:0]  poke_idx = '0;
  logic [31:0] poke_data = '0;
  int unsigned cyc = 0;
  int unsigned rx_idx = 0, tx_n = 0, req_cnt = 0;
  logic [15:0] tx_buf [0:63];

  assign dev_rx_valid = 1'b1;
  assign dev_rx_data  = 16'hA000 + 16'(rx_idx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 0;
    dev_tx_ready  <= (cyc % 4) != 1;
    mem_rsp_valid <= 1'b0;
    if (fill_req) begin
      for (int i = 0; i < 128; i++)
        mem[i] <= {16'(2*i+1) ^ 16'h5A00, 16'(2*i) ^ 16'h5A00};
    end else if (poke_en) mem[poke_idx] <= poke_data;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (mem_req_addr[1]) mem[mem_req_addr[8:2]][31:16] <= mem_req_wdata;
        else                 mem[mem_req_addr[8:2]][15:0]  <= mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_req_addr[1] ? {16'h0, mem[mem_req_addr[8:2]][31:16]}
                                         : mem[mem_req_addr[8:2]];
      end
    end
    if (dev_rx_valid && dev_rx_ready) rx_idx <= rx_idx + 1;
    if (dev_tx_valid && dev_tx_ready) begin
      tx_buf[tx_n[5:0]] <= dev_tx_data;
      tx_n <= tx_n + 1;
    end
  end

  int n_chk = 0, n_err = 0;
  int viol_r8 = 0, viol_r13 = 0;
  logic in_abort = 1'b0;
  logic p_txh = 1'b0, p_rqh = 1'b0;
  logic [15:0] p_txd;
  logic [31:0] p_rqa;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) req_cnt <= req_cnt + 1;
      if (status[0] && status[1]) viol_r8++;
      if (!in_abort && p_txh && !(dev_tx_valid && dev_tx_data == p_txd)) viol_r13++;
      if (!in_abort && p_rqh && !(mem_req_valid && mem_req_addr == p_rqa)) viol_r13++;
      p_txh = dev_tx_valid && !dev_tx_ready;
      p_txd = dev_tx_data;
      p_rqh = mem_req_valid && !mem_req_ready && !mem_req_we;
      p_rqa = mem_req_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_wr = 1'b1; base_wdata = v;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    @(negedge clk); poke_en = 1'b1; poke_idx = 7'(idx); poke_data = v;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic fill();
    @(negedge clk); fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (status[0] && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(req, 32'hDEAD, 32'h0);
  endtask

  function automatic logic [15:0] half_at(input logic [31:0] a);
    return a[1] ? mem[a[8:2]][31:16] : mem[a[8:2]][15:0];
  endfunction

  function automatic logic [15:0] pattern(input logic [31:0] a);
    return 16'(a >> 1) ^ 16'h5A00;
  endfunction

  // {dir, data address, length word, expected status, expected beats}
  localparam logic [80:0] VEC [6] = '{
    {1'b0, 32'h0000_0100, 32'h0000_0008, 8'h02, 8'd4},
    {1'b1, 32'h0000_0140, 32'h0000_0006, 8'h02, 8'd3},
    {1'b0, 32'h0000_0110, 32'h0000_0007, 8'h04, 8'd0},
    {1'b0, 32'h0000_0120, 32'h0000_0000, 8'h02, 8'd0},
    {1'b1, 32'h0000_0160, 32'hE000_0004, 8'h02, 8'd2},
    {1'b0, 32'h0000_0132, 32'h0000_0002, 8'h02, 8'd1}
  };

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 32'h0);
    chk("R1 dev_tx_valid", 32'(dev_tx_valid), 32'h0);
    chk("R1 dev_rx_ready", 32'(dev_rx_ready), 32'h0);

    for (int v = 0; v < 6; v++) begin
      logic d; logic [31:0] a, l; logic [7:0] es, ec;
      int unsigned tb0, rb0, cnt;
      {d, a, l, es, ec} = VEC[v];
      fill();
      poke(0, a | 32'h1);
      poke(1, l);
      set_base(32'h0);
      tb0 = tx_n; rb0 = rx_idx;
      ctrl({5'b0, d, 2'b01});
      chk("R8 active after start", 32'(status[0]), 32'h1);
      wait_idle("R8 finish");
      chk((es == 8'h04) ? "R7 status" : "R8 status", 32'(status), 32'(es));
      cnt = d ? (rx_idx - rb0) : (tx_n - tb0);
      chk(d ? "R5 beats" : "R6/R7 beats", 32'(cnt), 32'(ec));
      for (int k = 0; k < int'(ec); k++) begin
        if (d) chk(v == 4 ? "R6 data" : "R5 data", 32'(half_at(a + 32'(2*k))),
                   32'(16'hA000 + 16'(rb0 + k)));
        else   chk("R2 R4 data", 32'(tx_buf[(tb0 + k) % 64]), 32'(pattern(a + 32'(2*k))));
      end
    end

    // R3: two-entry table at 0x20
    begin
      int unsigned tb0;
      logic [31:0] exp_a [5] = '{32'h180, 32'h182, 32'h188, 32'h18A, 32'h18C};
      fill();
      poke(8, 32'h180); poke(9, 32'h4);
      poke(10, 32'h189); poke(11, 32'h6);
      set_base(32'h20);
      tb0 = tx_n;
      ctrl(8'h01);
      wait_idle("R3 finish");
      chk("R3 status", 32'(status), 32'h02);
      chk("R3 beats", tx_n - tb0, 32'd5);
      for (int k = 0; k < 5; k++)
        chk("R3 data order", 32'(tx_buf[(tb0 + k) % 64]), 32'(pattern(exp_a[k])));
    end

    // R9: stop while active
    begin
      int unsigned t0, r0;
      fill();
      poke(0, 32'h101); poke(1, 32'h40);
      set_base(32'h0);
      in_abort = 1'b1;
      ctrl(8'h01);
      repeat (6) @(negedge clk);
      ctrl(8'h03);
      chk("R9 active cleared", 32'(status), 32'h0);
      t0 = tx_n; r0 = req_cnt;
      repeat (20) @(negedge clk);
      chk("R9 no device beats", tx_n, t0);
      chk("R9 no requests", req_cnt, r0);
      in_abort = 1'b0;
    end

    // R11: base write during a run is dropped
    begin
      int unsigned tb0;
      fill();
      poke(0, 32'h101); poke(1, 32'h20);
      poke(16, 32'h1C1); poke(17, 32'h2);
      set_base(32'h0);
      ctrl(8'h01);
      set_base(32'h40);
      wait_idle("R11 first run");
      tb0 = tx_n;
      ctrl(8'h01);
      wait_idle("R11 second run");
      chk("R11 table base kept", tx_n - tb0, 32'd16);
    end

    // R10: reset hold
    ctrl(8'h80);
    chk("R10 flags cleared", 32'(status), 32'h0);
    ctrl(8'h81);
    chk("R10 start with hold", 32'(status[0]), 32'h0);
    ctrl(8'h01);
    chk("R10 start while held", 32'(status[0]), 32'h0);
    ctrl(8'h00);
    ctrl(8'h01);
    chk("R10 start after release", 32'(status[0]), 32'h1);
    wait_idle("R10 finish");
    chk("R10 end status", 32'(status), 32'h02);

    // R12: device interrupt flag
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    chk("R12 flag set", 32'(status[4]), 32'h1);
    chk("R12 no start", 32'(status[0]), 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 sticky", 32'(status[4]), 32'h1);
    ctrl(8'h01);
    chk("R12 cleared by start", 32'(status[4]), 32'h0);
    wait_idle("R12 finish");

    chk("R8 never active with end", viol_r8, 0);
    chk("R13 hold under back-pressure", viol_r13, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule